// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block takes two 32-bit binary floating-point operands (1 sign bit, 8 biased exponent bits, 23 fraction bits) and returns their product in the same format. It also returns three flags: overflow, underflow and invalid. A small controller runs one operation at a time. `in_ready` is high only while the controller is idle. A pair of operands is taken on a rising edge where `in_valid` and `in_ready` are both high. The result appears three edges later, with a one-cycle `out_valid` pulse, and stays on the outputs until the next result replaces it.

The datapath works like this. It restores the hidden leading one of each significand and forms the full 48-bit product. It adds the two biased exponents and removes one copy of the bias. If the product is 2.0 or more, it shifts right once. It rounds to nearest, with ties going to the even value, using a guard bit and a sticky bit. If rounding carries out of the significand, it normalizes a second time. Exponent-field zero on an input counts as zero, so subnormal inputs are flushed. A result below the normal range is flushed to a signed zero. The special cases for zero, infinity and NaN are resolved before the normal result is used.

The controller has four states. `ST_IDLE` waits for operands. `ST_MUL` classifies the operands, forms the exponent sum and registers the significand product. `ST_RND` normalizes, rounds and packs the result. `ST_OUT` presents the new result. The transitions are: `ST_IDLE` to `ST_MUL` when operands are accepted; `ST_MUL` to `ST_RND` unconditionally; `ST_RND` to `ST_OUT` unconditionally; `ST_OUT` to `ST_IDLE` unconditionally.

Top module: `fp32_mul_unit`

## Requirements
- R1: `in_ready` is 1 only in the idle state. Operands are taken on an edge where `in_valid` and `in_ready` are both 1. `out_valid` is 1 for exactly one cycle, after the third rising edge that follows acceptance. Operand changes while the block is busy do not affect the result.
- R2: For finite non-zero operands, result bit 31 is the XOR of the two operand sign bits.
- R3: For normal operands, the result exponent field equals ea + eb - 127, before normalization and rounding adjust it.
- R4: When the significand product is 2.0 or more, it is shifted right by one and the exponent is incremented (1.5 x 1.5 gives 0x40100000).
- R5: The fraction is rounded to 23 bits, to nearest with ties to even. The guard bit is the first bit below the kept fraction. The sticky bit is the OR of all lower product bits.
- R6: If rounding carries out of the significand, the fraction becomes zero and the exponent is incremented again.
- R7: If the final exponent is 255 or more, the result is a signed infinity (exponent field 0xFF, fraction 0) and overflow is 1. An exponent of 254 with an all-ones fraction is returned unchanged, with no flag.
- R8: If the final exponent is 0 or less, the result is a signed zero and underflow is 1. An exponent of exactly 1 gives a normal result with no flag.
- R9: An operand with exponent field 0 counts as zero. Zero times a finite value gives a zero with the XOR sign, exponent and fraction 0, and no flag.
- R10: Infinity times a non-zero finite value or an infinity gives an infinity with the XOR sign and no flag.
- R11: Any NaN operand gives the quiet NaN 0x7FC00000, with invalid 0. Zero times infinity (no NaN involved) gives 0x7FC00000 with invalid 1.
- R12: At most one of the three flags is 1 at a time. The result and flags hold their value between `out_valid` pulses. After reset, the result and flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operand pair is present |
| in_ready | output | 1 | Block is idle and will take operands |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 32 | Product |
| out_ovf | output | 1 | Result overflowed to infinity |
| out_unf | output | 1 | Result underflowed to zero |
| out_inv | output | 1 | Zero times infinity |

## Verification
The assertions assume that `in_valid`, `in_a` and `in_b` are known values whenever they are sampled, and that they change only away from the rising edge. The bench meets this by driving them only at falling edges and by holding `in_valid` low from time zero. The latency property also assumes that an accepted pair is never cut short by reset. The bench asserts reset only at the start, before any operation is issued.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int EW   = 8;
    localparam int FW   = 23;
    localparam int WW   = EW + FW + 1;
    localparam int SW   = FW + 1;
    localparam int PW   = 2 * SW;
    localparam int XW   = EW + 2;
    localparam int BIAS = (1 << (EW - 1)) - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_RND  = 2'd2,
        ST_OUT  = 2'd3
    } fpm_state_e;

    typedef struct packed {
        logic is_zero;
        logic is_inf;
        logic is_nan;
    } fpm_class_t;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inv;
    } fpm_flags_t;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
#(
    parameter int EXP_W  = EW,
    parameter int FRAC_W = FW
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output fpm_class_t            cls,
    output logic [FRAC_W:0]       sig,
    output logic [EXP_W-1:0]      expo,
    output logic                  sgn
);
    localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};

    logic [EXP_W-1:0]  e_fld;
    logic [FRAC_W-1:0] f_fld;

    always_comb begin
        sgn   = op[EXP_W+FRAC_W];
        e_fld = op[EXP_W+FRAC_W-1:FRAC_W];
        f_fld = op[FRAC_W-1:0];
        expo  = e_fld;
        // exponent field zero: zero or subnormal, both treated as zero
        cls.is_zero = (e_fld == '0);
        cls.is_inf  = (e_fld == EXP_ONES) && (f_fld == '0);
        cls.is_nan  = (e_fld == EXP_ONES) && (f_fld != '0);
        sig = {1'b1, f_fld};
    end
endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul
    import fpm_pkg::*;
#(
    parameter int EXP_W = EW,
    parameter int SIG_W = SW
) (
    input  logic [EXP_W-1:0]        ea,
    input  logic [EXP_W-1:0]        eb,
    input  logic [SIG_W-1:0]        ma,
    input  logic [SIG_W-1:0]        mb,
    output logic signed [EXP_W+1:0] esum,
    output logic [2*SIG_W-1:0]      prod
);
    localparam int EXW = EXP_W + 2;
    localparam logic signed [EXW-1:0] BIAS_X = EXW'((1 << (EXP_W - 1)) - 1);

    logic signed [EXW-1:0] ea_x;
    logic signed [EXW-1:0] eb_x;

    always_comb begin
        ea_x = $signed({2'b00, ea});
        eb_x = $signed({2'b00, eb});
        // two biased exponents carry the bias twice; drop one copy
        esum = ea_x + eb_x - BIAS_X;
        prod = {{SIG_W{1'b0}}, ma} * {{SIG_W{1'b0}}, mb};
    end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
    import fpm_pkg::*;
#(
    parameter int EXP_W  = EW,
    parameter int FRAC_W = FW
) (
    input  logic                      sgn,
    input  fpm_class_t                ca,
    input  fpm_class_t                cb,
    input  logic signed [EXP_W+1:0]   esum,
    input  logic [2*FRAC_W+1:0]       prod,
    output logic [EXP_W+FRAC_W:0]     word,
    output fpm_flags_t                flg
);
    localparam int EXW  = EXP_W + 2;
    localparam int PRW  = 2 * FRAC_W + 2;
    localparam logic signed [EXW-1:0] E_TOP = EXW'((1 << EXP_W) - 1);
    localparam logic [EXP_W-1:0]  EXP_ONES = {EXP_W{1'b1}};
    localparam logic [FRAC_W-1:0] QUIET    = {1'b1, {(FRAC_W-1){1'b0}}};

    logic                  hi;
    logic signed [EXW-1:0] e_norm;
    logic signed [EXW-1:0] e_fin;
    logic [FRAC_W-1:0]     kept;
    logic                  guard;
    logic                  sticky;
    logic                  up;
    logic [FRAC_W:0]       inc;
    logic                  carry;
    logic [FRAC_W-1:0]     frac_fin;
    logic                  any_nan;
    logic                  any_inf;
    logic                  any_zero;

    // first normalization: at most one right shift
    always_comb begin
        hi = prod[PRW-1];
        if (hi) begin
            kept   = prod[PRW-2 -: FRAC_W];
            guard  = prod[PRW-2-FRAC_W];
            sticky = |prod[PRW-3-FRAC_W:0];
        end else begin
            kept   = prod[PRW-3 -: FRAC_W];
            guard  = prod[PRW-3-FRAC_W];
            sticky = |prod[PRW-4-FRAC_W:0];
        end
        e_norm = esum + $signed({{(EXW-1){1'b0}}, hi});
    end

    // round to nearest, ties to even, then renormalize on carry out
    always_comb begin
        up       = guard & (sticky | kept[0]);
        inc      = {1'b0, kept} + {{FRAC_W{1'b0}}, up};
        carry    = inc[FRAC_W];
        frac_fin = carry ? '0 : inc[FRAC_W-1:0];
        e_fin    = e_norm + $signed({{(EXW-1){1'b0}}, carry});
    end

    // special operands first, then range check on the rounded value
    always_comb begin
        any_nan  = ca.is_nan  | cb.is_nan;
        any_inf  = ca.is_inf  | cb.is_inf;
        any_zero = ca.is_zero | cb.is_zero;
        flg      = '0;
        word     = '0;
        if (any_nan) begin
            word = {1'b0, EXP_ONES, QUIET};
        end else if (any_inf && any_zero) begin
            word    = {1'b0, EXP_ONES, QUIET};
            flg.inv = 1'b1;
        end else if (any_inf) begin
            word = {sgn, EXP_ONES, {FRAC_W{1'b0}}};
        end else if (any_zero) begin
            word = {sgn, {(EXP_W+FRAC_W){1'b0}}};
        end else if (e_fin >= E_TOP) begin
            word    = {sgn, EXP_ONES, {FRAC_W{1'b0}}};
            flg.ovf = 1'b1;
        end else if (e_fin <= 0) begin
            word    = {sgn, {(EXP_W+FRAC_W){1'b0}}};
            flg.unf = 1'b1;
        end else begin
            word = {sgn, e_fin[EXP_W-1:0], frac_fin};
        end
    end
endmodule

// File: rtl/fp32_mul_unit.sv
module fp32_mul_unit
    import fpm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [31:0]   in_a,
    input  logic [31:0]   in_b,
    output logic          out_valid,
    output logic [31:0]   out_result,
    output logic          out_ovf,
    output logic          out_unf,
    output logic          out_inv
);
    fpm_state_e state;
    fpm_state_e state_nx;

    logic [WW-1:0] opa_q;
    logic [WW-1:0] opb_q;

    fpm_class_t    cls_u [2];
    logic [SW-1:0] sig_u [2];
    logic [EW-1:0] exp_u [2];
    logic          sgn_u [2];
    logic [WW-1:0] op_u  [2];

    logic signed [XW-1:0] esum_c;
    logic [PW-1:0]        prod_c;

    fpm_class_t           ca_q;
    fpm_class_t           cb_q;
    logic                 sgn_q;
    logic signed [XW-1:0] esum_q;
    logic [PW-1:0]        prod_q;

    logic [WW-1:0] word_c;
    fpm_flags_t    flg_c;

    logic accept;

    assign op_u[0] = opa_q;
    assign op_u[1] = opb_q;

    for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
        fpm_unpack #(.EXP_W(EW), .FRAC_W(FW)) u_unpack (
            .op   (op_u[gi]),
            .cls  (cls_u[gi]),
            .sig  (sig_u[gi]),
            .expo (exp_u[gi]),
            .sgn  (sgn_u[gi])
        );
    end

    fpm_sigmul #(.EXP_W(EW), .SIG_W(SW)) u_sigmul (
        .ea   (exp_u[0]),
        .eb   (exp_u[1]),
        .ma   (sig_u[0]),
        .mb   (sig_u[1]),
        .esum (esum_c),
        .prod (prod_c)
    );

    fpm_round #(.EXP_W(EW), .FRAC_W(FW)) u_round (
        .sgn  (sgn_q),
        .ca   (ca_q),
        .cb   (cb_q),
        .esum (esum_q),
        .prod (prod_q),
        .word (word_c),
        .flg  (flg_c)
    );

    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state == ST_OUT);
    assign accept    = in_valid && in_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_MUL;
            ST_MUL:  state_nx = ST_RND;
            ST_RND:  state_nx = ST_OUT;
            ST_OUT:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q      <= '0;
            opb_q      <= '0;
            ca_q       <= '0;
            cb_q       <= '0;
            sgn_q      <= 1'b0;
            esum_q     <= '0;
            prod_q     <= '0;
            out_result <= '0;
            out_ovf    <= 1'b0;
            out_unf    <= 1'b0;
            out_inv    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        opa_q <= in_a;
                        opb_q <= in_b;
                    end
                end
                ST_MUL: begin
                    ca_q   <= cls_u[0];
                    cb_q   <= cls_u[1];
                    sgn_q  <= sgn_u[0] ^ sgn_u[1];
                    esum_q <= esum_c;
                    prod_q <= prod_c;
                end
                ST_RND: begin
                    out_result <= word_c;
                    out_ovf    <= flg_c.ovf;
                    out_unf    <= flg_c.unf;
                    out_inv    <= flg_c.inv;
                end
                ST_OUT: begin
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic [31:0] out_result,
    input logic        out_ovf,
    input logic        out_unf,
    input logic        out_inv
);
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R1
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R1
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !out_valid ##1 !out_valid ##1 out_valid); // R1
    AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovf) |-> (out_result[30:0] == 31'h7F800000)); // R7
    AST_UNF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_unf) |-> (out_result[30:0] == 31'h0)); // R8
    AST_INV_IS_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_inv) |-> (out_result == 32'h7FC00000)); // R11
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({out_ovf, out_unf, out_inv}) <= 1); // R12
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_result)); // R12
endmodule

bind fp32_mul_unit fpm_mul_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_ovf    (out_ovf),
    .out_unf    (out_unf),
    .out_inv    (out_inv)
);

// File: tb/fp32_mul_unit_test.sv
module fp32_mul_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic [2:0]  f;    // {ovf, unf, inv}
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{32'h40000000, 32'h40400000, 32'h40C00000, 3'b000, 8'd3},  // R3 2*3
        '{32'hC0000000, 32'h40400000, 32'hC0C00000, 3'b000, 8'd2},  // R2 -2*3
        '{32'hBF400000, 32'hBF400000, 32'h3F100000, 3'b000, 8'd2},  // R2 -0.75*-0.75
        '{32'h3FC00000, 32'h3FC00000, 32'h40100000, 3'b000, 8'd4},  // R4 1.5*1.5
        '{32'h3F800001, 32'h3FC00000, 32'h3FC00002, 3'b000, 8'd5},  // R5 tie, odd lsb rounds up
        '{32'h3F800003, 32'h3FC00000, 32'h3FC00004, 3'b000, 8'd5},  // R5 tie, even lsb kept
        '{32'h3FA1E58F, 32'h3FCA6691, 32'h40000000, 3'b000, 8'd6},  // R6 product 2^47-1, carry out
        '{32'h7F000000, 32'h40000000, 32'h7F800000, 3'b100, 8'd7},  // R7 exponent reaches 255
        '{32'hFF7FFFFF, 32'h7F7FFFFF, 32'hFF800000, 3'b100, 8'd7},  // R7 signed overflow
        '{32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 3'b000, 8'd7},  // R7 largest finite kept
        '{32'h00800000, 32'h3F000000, 32'h00000000, 3'b010, 8'd8},  // R8 below normal range
        '{32'h80800000, 32'h3F000000, 32'h80000000, 3'b010, 8'd8},  // R8 signed flush
        '{32'h20000000, 32'h20000000, 32'h00800000, 3'b000, 8'd8},  // R8 exponent exactly 1
        '{32'h80000000, 32'h40400000, 32'h80000000, 3'b000, 8'd9},  // R9 -0*3
        '{32'h00000001, 32'h40000000, 32'h00000000, 3'b000, 8'd9},  // R9 subnormal as zero
        '{32'h7F800000, 32'hC0000000, 32'hFF800000, 3'b000, 8'd10}, // R10 inf*-2
        '{32'hFF800000, 32'hFF800000, 32'h7F800000, 3'b000, 8'd10}, // R10 -inf*-inf
        '{32'h00000000, 32'h7F800000, 32'h7FC00000, 3'b001, 8'd11}, // R11 zero*inf
        '{32'h7F800001, 32'h3F800000, 32'h7FC00000, 3'b000, 8'd11}, // R11 NaN propagates
        '{32'hFFC00000, 32'h00000000, 32'h7FC00000, 3'b000, 8'd11}  // R11 NaN beats invalid
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_ovf;
    logic        out_unf;
    logic        out_inv;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    fp32_mul_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_ovf    (out_ovf),
        .out_unf    (out_unf),
        .out_inv    (out_inv)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    // drives one pair; if hold_junk, in_valid stays high with other operands while busy
    task automatic issue(input logic [31:0] a, input logic [31:0] b, input string req,
                         input bit hold_junk);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_a = a;
        in_b = b;
        in_valid = 1'b1;
        @(negedge clk);
        if (hold_junk) begin
            in_a = 32'h40E00000;
            in_b = 32'h41100000;
        end else begin
            in_valid = 1'b0;
        end
        check(req, "out_valid one cycle after accept", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        check(req, "out_valid two cycles after accept", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "out_valid three cycles after accept", {31'b0, out_valid}, 32'd1);
        check(req, "in_ready while presenting", {31'b0, in_ready}, 32'd0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R1 watchdog: actual=running expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", "reset result", out_result, 32'h0);
        check("R12", "reset flags", {29'b0, out_ovf, out_unf, out_inv}, 32'h0);
        check("R1", "reset out_valid", {31'b0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", {31'b0, in_ready}, 32'd1);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].req);
            issue(VEC[i].a, VEC[i].b, tag, 1'b0);
            check(tag, $sformatf("result vec %0d", i), out_result, VEC[i].r);
            check(tag, $sformatf("flags vec %0d", i),
                  {29'b0, out_ovf, out_unf, out_inv}, {29'b0, VEC[i].f});
        end

        // R1: operands changed while busy must not alter the accepted pair
        issue(32'h40000000, 32'h40800000, "R1", 1'b1);
        check("R1", "busy operand change ignored", out_result, 32'h41000000);

        // R12: outputs hold after the pulse until the next result
        @(negedge clk);
        check("R12", "pulse ends", {31'b0, out_valid}, 32'd0);
        check("R12", "ready again", {31'b0, in_ready}, 32'd1);
        repeat (4) @(negedge clk);
        check("R12", "result held", out_result, 32'h41000000);

        // R12: flag from an overflow clears on the next normal result
        issue(32'h7F000000, 32'h7F000000, "R7", 1'b0);
        check("R7", "overflow flag", {31'b0, out_ovf}, 32'd1);
        issue(32'h3F800000, 32'h3F800000, "R12", 1'b0);
        check("R12", "flags cleared", {29'b0, out_ovf, out_unf, out_inv}, 32'h0);
        check("R3", "one times one", out_result, 32'h3F800000);

        finished = 1'b1;
        summary();
    end
endmodule